// File: doc/BRIEF.md
# Burst Beat Address Generator

This block produces the byte address of each beat of a memory-mapped burst. The burst is described by a start address, a length field, a size field and a burst kind. A load strobe captures these values. An advance strobe then moves the generator forward one beat at a time. On every beat the block presents the beat address, the beat index and a flag that marks the final beat.

The block supports three burst kinds. A fixed burst repeats the start address. An incrementing burst steps the address by the beat size. A wrapping burst steps the same way but stays inside an aligned window. The block also checks the burst parameters when they are loaded. It raises an error flag for an illegal wrap length, for an incrementing burst that would run past a 4096-byte page, and for the reserved kind code. It does not take part in any channel handshake and moves no data, so a burst master or a slave can place it next to its own control logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `addr_o`, `beat_o`, `last_o`, `active_o` and `err_o` are all zero.
- R2: When `load_i` is high at a clock edge with legal parameters, the outputs just after that edge show `addr_o` = `start_addr_i`, `beat_o` = 0, `active_o` = 1 and `err_o` = 0.
- R3: For kind code 2'b00 (fixed), every beat of the burst shows the start address.
- R4: For kind code 2'b01 (incrementing), beat i shows start + i·2^size. The size field `size_i` encodes 2^size bytes per beat, for sizes 0 to 7.
- R5: For kind code 2'b10 (wrapping), let W = 2^size·(len+1) and low = floor(start/W)·W. Beat i shows low + ((start − low + i·2^size) mod W). In words, the beat after the top of the window returns to low.
- R6: The burst has `len_i`+1 beats. `last_o` is high exactly when the beat index equals `len_i`. An advance on the last beat ends the burst: `active_o` and `last_o` fall and `addr_o` holds its value.
- R7: A wrapping burst is legal only with `len_i` equal to 1, 3, 7 or 15 (2, 4, 8 or 16 beats). Any other length raises `err_o`.
- R8: An incrementing burst raises `err_o` when (start mod 4096) + (len+1)·2^size > 4096. A burst that ends exactly at the page edge is legal.
- R9: Kind code 2'b11 is reserved and always raises `err_o`. A fixed burst is legal for any length.
- R10: While `active_o` is low, `advance_i` has no effect on `addr_o`, `beat_o`, `last_o` or `active_o`.
- R11: When `load_i` and `advance_i` are high at the same edge, the load takes effect and the advance is dropped.
- R12: A load with illegal parameters leaves `active_o` low and `addr_o` at the start address. `err_o` stays high until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture burst parameters and go to beat 0 |
| advance_i | input | 1 | Step to the next beat |
| start_addr_i | input | ADDR_W | Byte address of beat 0 |
| len_i | input | LEN_W | Beat count minus one |
| size_i | input | SIZE_W | log2 of bytes per beat |
| kind_i | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | LEN_W | Index of the current beat |
| last_o | output | 1 | Current beat is the final one |
| active_o | output | 1 | A legal burst is in progress |
| err_o | output | 1 | Last loaded parameters were illegal |

## Verification
A load and an advance can arrive at the same edge. The load must win, so the new burst starts cleanly at beat 0. The bench provokes this by raising both strobes in the middle of a running burst. At the next sample it expects the new start address and beat index 0, not one beat past either burst. The same judgement applies when an advance lands on the last beat at the edge that a new load also sees.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  // log2 of the page that an incrementing burst must stay inside
  localparam int PAGE_LOG2 = 12;
endpackage

// File: rtl/bag_param_check.sv
module bag_param_check
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  localparam int SPAN_W = LEN_W + (1 << SIZE_W)
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        kind,
  output logic              legal,
  output logic [SPAN_W-1:0] wrap_mask
);
  logic [SPAN_W-1:0] beats;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W:0]   end_off;
  logic              crosses_page;
  logic              wrap_len_ok;

  always_comb begin
    beats        = SPAN_W'(len) + SPAN_W'(1);
    span         = beats << size;
    wrap_mask    = span - SPAN_W'(1);
    end_off      = (SPAN_W+1)'(start_addr[PAGE_LOG2-1:0]) + (SPAN_W+1)'(span);
    crosses_page = end_off > (SPAN_W+1)'(1 << PAGE_LOG2);
    wrap_len_ok  = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                   (len == LEN_W'(7)) || (len == LEN_W'(15));
    case (burst_kind_e'(kind))
      BK_FIXED: legal = 1'b1;
      BK_INCR:  legal = !crosses_page;
      BK_WRAP:  legal = wrap_len_ok;
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPAN_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        kind,
  input  logic [SPAN_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] mask_a;

  always_comb begin
    step    = ADDR_W'(1) << size;
    stepped = cur_addr + step;
    mask_a  = ADDR_W'(wrap_mask);
    case (burst_kind_e'(kind))
      BK_INCR: next_addr = stepped;
      BK_WRAP: next_addr = (cur_addr & ~mask_a) | (stepped & mask_a);
      default: next_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             start_ok,
  input  logic             advance,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] beat,
  output logic             last,
  output logic             active
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat   <= '0;
      len_q  <= '0;
      last   <= 1'b0;
      active <= 1'b0;
    end else if (load) begin
      beat   <= '0;
      len_q  <= len;
      active <= start_ok;
      last   <= start_ok && (len == '0);
    end else if (active && advance) begin
      if (last) begin
        active <= 1'b0;
        last   <= 1'b0;
      end else begin
        beat <= beat + LEN_W'(1);
        last <= (beat + LEN_W'(1)) == len_q;
      end
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  beat_o,
  output logic              last_o,
  output logic              active_o,
  output logic              err_o
);
  localparam int SPAN_W = LEN_W + (1 << SIZE_W);

  logic              legal;
  logic [SPAN_W-1:0] mask_new;
  logic [SPAN_W-1:0] mask_q;
  logic [1:0]        kind_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] next_addr;

  bag_param_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_check (
    .start_addr(start_addr_i),
    .len       (len_i),
    .size      (size_i),
    .kind      (kind_i),
    .legal     (legal),
    .wrap_mask (mask_new)
  );

  bag_next_addr #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .SIZE_W(SIZE_W)) u_next (
    .cur_addr (addr_o),
    .size     (size_q),
    .kind     (kind_q),
    .wrap_mask(mask_q),
    .next_addr(next_addr)
  );

  bag_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load_i),
    .start_ok(legal),
    .advance (advance_i),
    .len     (len_i),
    .beat    (beat_o),
    .last    (last_o),
    .active  (active_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      kind_q <= '0;
      size_q <= '0;
      mask_q <= '0;
      err_o  <= 1'b0;
    end else if (load_i) begin
      addr_o <= start_addr_i;
      kind_q <= kind_i;
      size_q <= size_i;
      mask_q <= mask_new;
      err_o  <= !legal;
    end else if (active_o && advance_i && !last_o) begin
      addr_o <= next_addr;
    end
  end
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int SPAN_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              advance_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [LEN_W-1:0]  beat_o,
  input logic              last_o,
  input logic              active_o,
  input logic              err_o,
  input logic [1:0]        kind_q,
  input logic [SIZE_W-1:0] size_q,
  input logic [SPAN_W-1:0] mask_q
);
  logic step_ok;
  assign step_ok = active_o && advance_i && !last_o && !load_i;

  // R2
  load_beat0_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (beat_o == '0) && (addr_o == $past(start_addr_i)));

  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && kind_q == 2'b00) |=> $stable(addr_o));

  // R4
  incr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && kind_q == 2'b01) |=>
      addr_o == $past(addr_o) + (ADDR_W'(1) << $past(size_q)));

  // R5
  wrap_window_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && kind_q == 2'b10) |=>
      ((addr_o ^ $past(addr_o)) & ~ADDR_W'($past(mask_q))) == '0);

  // R6
  last_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |-> active_o);

  // R6
  end_of_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && advance_i && last_o && !load_i) |=> !active_o && $stable(addr_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !load_i) |=> !active_o && $stable(addr_o) && $stable(beat_o));

  // R12
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !active_o);
endmodule

bind burst_addr_gen bag_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .SPAN_W(SPAN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .advance_i   (advance_i),
  .start_addr_i(start_addr_i),
  .addr_o      (addr_o),
  .beat_o      (beat_o),
  .last_o      (last_o),
  .active_o    (active_o),
  .err_o       (err_o),
  .kind_q      (kind_q),
  .size_q      (size_q),
  .mask_q      (mask_q)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic          advance_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [LW-1:0] len_i = '0;
  logic [SW-1:0] size_i = '0;
  logic [1:0]    kind_i = '0;
  logic [AW-1:0] addr_o;
  logic [LW-1:0] beat_o;
  logic          last_o, active_o, err_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .SIZE_W(SW)) u_dut (.*);

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_error(longint start, int len, int size, int kind);
    longint bytes = longint'(1) << size;
    longint beats = len + 1;
    if (kind == 3) return 1'b1;                                   // R9
    if (kind == 2) return !(beats == 2 || beats == 4 || beats == 8 || beats == 16); // R7
    if (kind == 1) return (start % 4096) + beats * bytes > 4096;  // R8
    return 1'b0;
  endfunction

  function automatic longint exp_addr(longint start, int len, int size, int kind, int i);
    longint bytes = longint'(1) << size;
    longint w = bytes * (len + 1);
    longint low = (start / w) * w;
    if (kind == 0) return start;                       // R3
    if (kind == 1) return start + i * bytes;           // R4
    return low + ((start - low + i * bytes) % w);      // R5
  endfunction

  task automatic run_burst(longint start, int len, int size, int kind);
    bit e;
    @(negedge clk);
    load_i = 1'b1; start_addr_i = AW'(start); len_i = LW'(len);
    size_i = SW'(size); kind_i = 2'(kind); advance_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0;
    e = exp_error(start, len, size, kind);
    check("R7/R8/R9 err_o", err_o, e);
    if (e) begin
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
      check("R12 active_o", active_o, 0);
      check("R12 addr_o", addr_o, start);
      check("R12 err_o held", err_o, 1);
      return;
    end
    check("R2 active_o", active_o, 1);
    advance_i = 1'b1;
    for (int i = 0; i <= len; i++) begin
      check("R3/R4/R5 addr_o", addr_o, exp_addr(start, len, size, kind, i));
      check("R6 beat_o", beat_o, i);
      check("R6 last_o", last_o, i == len);
      @(negedge clk);
    end
    advance_i = 1'b0;
    check("R6 burst end active_o", active_o, 0);
    check("R6 burst end last_o", last_o, 0);
    check("R6 addr holds", addr_o, exp_addr(start, len, size, kind, len));
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lens_i[5] = '{0, 1, 7, 15, 255};
    int lens_w[8] = '{0, 1, 2, 3, 4, 7, 15, 255};
    logic [AW-1:0] a0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 addr_o", addr_o, 0);
    check("R1 active_o", active_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 beat_o", beat_o, 0);
    check("R1 last_o", last_o, 0);
    check("R1 err_o", err_o, 0);

    // R10 advance while idle
    advance_i = 1'b1;
    repeat (3) @(negedge clk);
    advance_i = 1'b0;
    check("R10 active_o", active_o, 0);
    check("R10 addr_o", addr_o, 0);
    check("R10 beat_o", beat_o, 0);

    // R3 fixed, any length legal (R9)
    for (int s = 0; s < 8; s += 3)
      foreach (lens_i[k]) run_burst(64'h1FF0, lens_i[k], s, 0);

    // R4 / R8 incrementing
    for (int s = 0; s < 8; s++)
      foreach (lens_i[k]) begin
        longint b = longint'(1) << s;
        run_burst(64'h2000, lens_i[k], s, 1);
        run_burst(64'h2000 + 3 * b, lens_i[k], s, 1);
        run_burst(64'h3000 - (lens_i[k] + 1) * b, lens_i[k], s, 1); // ends exactly at page edge
        run_burst(64'h3000 - 4 * b, lens_i[k], s, 1);
      end

    // R5 / R7 wrapping
    for (int s = 0; s < 8; s++)
      foreach (lens_w[k]) begin
        longint b = longint'(1) << s;
        longint w = b * (lens_w[k] + 1);
        run_burst(64'h5000, lens_w[k], s, 2);
        run_burst(64'h5000 + 3 * b, lens_w[k], s, 2);
        run_burst(64'h5000 + w - b, lens_w[k], s, 2);
      end

    // R9 reserved kind
    run_burst(64'h100, 3, 2, 3);

    // R11 load and advance together in mid burst
    @(negedge clk);
    load_i = 1'b1; start_addr_i = 32'h0000_4000; len_i = 8'd9; size_i = 3'd2; kind_i = 2'b01;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b1;
    repeat (3) @(negedge clk);
    a0 = 32'h0000_7700;
    load_i = 1'b1; start_addr_i = a0; len_i = 8'd3; size_i = 3'd3;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b0;
    check("R11 beat_o", beat_o, 0);
    check("R11 addr_o", addr_o, a0);
    check("R11 active_o", active_o, 1);
    // R11 load on the same edge as advance on the last beat
    advance_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 last_o before reload", last_o, 1);
    load_i = 1'b1; start_addr_i = 32'h0000_8000; len_i = 8'd1; kind_i = 2'b00;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b0;
    check("R11 reload active_o", active_o, 1);
    check("R11 reload addr_o", addr_o, 32'h0000_8000);
    check("R11 reload beat_o", beat_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule